// File: doc/BRIEF.md
# Earliest-Timestamp Output Arbiter

This block chooses, for each output of a four-port packet switch's data path, which input buffer sends its packet next. Each input buffer shows one candidate per output: its oldest packet bound for that output, with the 16-bit stamp it received on arrival. A data packet holds an 8-bit address, a 16-bit stamp and 29 bytes of payload. Only the stamp is used here. The arbiter gives each output to the candidate that has waited longest. Age is measured against a free-running time input, modulo 2^16, so a wrap of the time counter does not reverse the order.

The outputs are decided separately and in parallel. A tie in age goes to the input reached first in a rotating scan. The scan starts at `scan_start`, runs up to input 3, then wraps through input 0 to `scan_start`-1. The decision is registered. One clock edge after the candidates are sampled, the block presents a grant flag and a winner index for each output. In the same cycle it raises a one-cycle dequeue strobe to the winning input for that output.

Each candidate slot works as a stream source. `cand_valid` is its valid, and its dequeue strobe acts as the ready, one cycle late. A source must keep its candidate in place until the strobe arrives. Each output applies back-pressure through `out_ready`. While an output's ready is low, nothing is granted to that output and no strobe is raised for it, so every candidate for it stays queued.

Top module: `stamp_arbiter`

## Requirements
- R1: While reset is asserted, and on the first edge after it, all `grant_valid` and `deq` bits are 0.
- R2: For each output j, the grant goes to the valid candidate with the largest age. Age is (now_stamp − stamp) modulo 2^16. Candidate slot i*4+j is bit i*4+j of `cand_valid` and bits [16*(i*4+j)+15 : 16*(i*4+j)] of `cand_stamp`.
- R3: Age comparison is wrap-aware. With now 0x0020, stamp 0xFFF0 (age 0x30) beats stamp 0x0010 (age 0x10).
- R4: Among candidates of equal age, the winner is the one reached first in the scan. The scan runs scan_start, scan_start+1, …, 3, then 0, …, scan_start−1.
- R5: An output with no valid candidate has `grant_valid` low and its dequeue strobes all low.
- R6: When `out_ready[j]` is low, output j issues no grant and no strobe. Its candidates remain eligible and win once ready returns.
- R7: Grants and strobes are registered. They reflect the inputs sampled at the preceding rising edge and do not change between edges.
- R8: `deq[i*4+j]` is high exactly when `grant_valid[j]` is high and `grant_idx[2*j+1:2*j]` equals i. At most one strobe per output is high.
- R9: Outputs decide independently. One input may win several outputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| now_stamp | input | 16 | Current time, the reference for ages |
| scan_start | input | 2 | First input in the tie-break scan |
| cand_valid | input | 16 | Candidate present, bit i*4+j for input i, output j |
| cand_stamp | input | 256 | Candidate stamps, 16 bits per slot i*4+j |
| out_ready | input | 4 | Per-output back-pressure, high means accept |
| grant_valid | output | 4 | Output j granted this cycle |
| grant_idx | output | 8 | Winning input of output j in bits [2j+1:2j] |
| deq | output | 16 | One-cycle dequeue strobe, bit i*4+j |

## Verification
The assertions assume `scan_start` names an existing input. They assume a live candidate's age is below half the stamp range, so that "largest age" really means "oldest". They also assume a candidate and its stamp do not change until its strobe arrives. The bench drives inputs only on falling edges and keeps `scan_start` within 0..3. It uses small ages, except for the deliberate wrap and half-range cases. It holds stalled candidates unchanged across the back-pressure cycle.

// File: rtl/stamp_arb_pkg.sv
package stamp_arb_pkg;
  localparam int unsigned PORTS   = 4;
  localparam int unsigned STAMP_W = 16;
  localparam int unsigned IDX_W   = $clog2(PORTS);

  typedef logic [STAMP_W-1:0] stamp_t;

  // Wrap-aware age: elapsed time modulo the stamp range.
  function automatic stamp_t age_of(input stamp_t now, input stamp_t stamp);
    return stamp_t'(now - stamp);
  endfunction
endpackage

// File: rtl/stamp_pick.sv
module stamp_pick #(
  parameter int unsigned N  = 4,
  parameter int unsigned TW = 16,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]    v,
  input  logic [N*TW-1:0] stamps,
  input  logic [TW-1:0]   now,
  input  logic [IW-1:0]   start,
  output logic            pick_v,
  output logic [IW-1:0]   pick_idx
);
  logic [TW-1:0] age [N];
  logic [TW-1:0] sel_age;

  for (genvar i = 0; i < N; i++) begin : g_age
    assign age[i] = TW'(now - stamps[i*TW +: TW]);
  end

  // Rotating scan; replace only on a strictly larger age so ties stay with
  // the first input met.
  always_comb begin
    logic [IW:0] pos;
    pick_v   = 1'b0;
    pick_idx = '0;
    sel_age  = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, start} + (IW+1)'(k);
      if (pos >= (IW+1)'(N)) pos = pos - (IW+1)'(N);
      if (v[pos[IW-1:0]] && (!pick_v || age[pos[IW-1:0]] > sel_age)) begin
        pick_v   = 1'b1;
        pick_idx = pos[IW-1:0];
        sel_age  = age[pos[IW-1:0]];
      end
    end
  end

  always_comb begin
    a_r5_pick_iff_any: assert (pick_v == (|v));
    if (pick_v) begin
      for (int k = 0; k < N; k++) begin
        if (v[k]) begin
          a_r2_oldest_wins: assert (age[k] <= sel_age);
        end
      end
    end
  end
endmodule

// File: rtl/stamp_grant_stage.sv
module stamp_grant_stage #(
  parameter int unsigned N  = 4,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pick_v,
  input  logic [IW-1:0] pick_idx,
  input  logic          ready,
  output logic          gv,
  output logic [IW-1:0] gidx,
  output logic [N-1:0]  deq_col
);
  logic fire;
  assign fire = pick_v & ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gv   <= 1'b0;
      gidx <= '0;
    end else begin
      gv   <= fire;
      gidx <= pick_idx;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_deq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) deq_col[i] <= 1'b0;
      else        deq_col[i] <= fire && (pick_idx == IW'(i));
    end
  end

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(deq_col));
  a_r8_strobe_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
    gv |-> deq_col[gidx]);
  a_r8_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !gv |-> (deq_col == '0));
  a_r6_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> !gv);
endmodule

// File: rtl/stamp_arbiter.sv
module stamp_arbiter
  import stamp_arb_pkg::*;
#(
  parameter int unsigned N  = PORTS,
  parameter int unsigned TW = STAMP_W,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TW-1:0]     now_stamp,
  input  logic [IW-1:0]     scan_start,
  input  logic [N*N-1:0]    cand_valid,
  input  logic [N*N*TW-1:0] cand_stamp,
  input  logic [N-1:0]      out_ready,
  output logic [N-1:0]      grant_valid,
  output logic [N*IW-1:0]   grant_idx,
  output logic [N*N-1:0]    deq
);
  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0]    col_v;
    logic [N*TW-1:0] col_s;
    logic            pv;
    logic [IW-1:0]   pidx;
    logic [N-1:0]    dcol;

    for (genvar i = 0; i < N; i++) begin : g_col
      assign col_v[i]          = cand_valid[i*N + j];
      assign col_s[i*TW +: TW] = cand_stamp[(i*N + j)*TW +: TW];
      assign deq[i*N + j]      = dcol[i];
    end

    stamp_pick #(.N(N), .TW(TW), .IW(IW)) u_pick (
      .v(col_v), .stamps(col_s), .now(now_stamp), .start(scan_start),
      .pick_v(pv), .pick_idx(pidx)
    );

    stamp_grant_stage #(.N(N), .IW(IW)) u_stage (
      .clk(clk), .rst_n(rst_n), .pick_v(pv), .pick_idx(pidx),
      .ready(out_ready[j]), .gv(grant_valid[j]),
      .gidx(grant_idx[j*IW +: IW]), .deq_col(dcol)
    );

    a_r5_empty_column: assert property (@(posedge clk) disable iff (!rst_n)
      (col_v == '0) |=> !grant_valid[j]);
    a_r6_ready_granted: assert property (@(posedge clk) disable iff (!rst_n)
      ((col_v != '0) && out_ready[j]) |=> grant_valid[j]);
  end
endmodule

// File: tb/stamp_arbiter_tb_top.sv
module stamp_arbiter_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [15:0]  now_stamp;
  logic [1:0]   scan_start;
  logic [15:0]  cand_valid;
  logic [255:0] cand_stamp;
  logic [3:0]   out_ready;
  logic [3:0]   grant_valid;
  logic [7:0]   grant_idx;
  logic [15:0]  deq;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  stamp_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .now_stamp(now_stamp), .scan_start(scan_start),
    .cand_valid(cand_valid), .cand_stamp(cand_stamp), .out_ready(out_ready),
    .grant_valid(grant_valid), .grant_idx(grant_idx), .deq(deq)
  );

  task automatic clear_all();
    cand_valid = '0;
    cand_stamp = '0;
    out_ready  = 4'hF;
    scan_start = 2'd0;
  endtask

  task automatic put(input int i, input int j, input logic [15:0] s);
    cand_valid[i*4 + j]        = 1'b1;
    cand_stamp[(i*4 + j)*16 +: 16] = s;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic check_col(input int j, input bit ev, input int eidx, input string tag);
    bit ok;
    logic [3:0] col, ecol;
    for (int i = 0; i < 4; i++) begin
      col[i]  = deq[i*4 + j];
      ecol[i] = ev && (i == eidx);
    end
    ok = (grant_valid[j] == ev) && (col == ecol) &&
         (!ev || grant_idx[j*2 +: 2] == eidx[1:0]);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s out%0d: gv=%0b idx=%0d deqcol=%b expected gv=%0b idx=%0d deqcol=%b",
               tag, j, grant_valid[j], grant_idx[j*2 +: 2], col, ev, eidx, ecol);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    clear_all();
    put(0, 0, 16'd1);
    now_stamp = 16'd5;
    step();
    check_col(0, 0, 0, "R1 during reset");
    n_tests++;
    if (deq != 16'h0) begin
      n_fail++;
      $display("FAIL R1: deq=%h expected 0000", deq);
    end
    @(negedge clk);
    rst_n = 1'b1;
    clear_all();
    step();
    check_col(0, 0, 0, "R1 after release");
  endtask

  task automatic t_oldest();
    @(negedge clk);
    clear_all();
    now_stamp = 16'd1000;
    put(0, 0, 16'd900); put(1, 0, 16'd950); put(2, 0, 16'd500);
    cand_stamp[(3*4+0)*16 +: 16] = 16'd100; // not valid, ignored
    put(3, 1, 16'd999);
    put(1, 3, 16'd10); put(0, 3, 16'd20);
    step();
    check_col(0, 1, 2, "R2 oldest of three");
    check_col(1, 1, 3, "R2 single candidate");
    check_col(2, 0, 0, "R5 no candidate");
    check_col(3, 1, 1, "R2 smaller stamp older");
  endtask

  task automatic t_wrap();
    @(negedge clk);
    clear_all();
    now_stamp = 16'h0020;
    put(0, 0, 16'h0010); put(1, 0, 16'hFFF0);
    put(3, 1, 16'h0000); put(2, 1, 16'h8000);
    step();
    check_col(0, 1, 1, "R3 stamp before wrap is older");
    check_col(1, 1, 2, "R3 half-range age");
  endtask

  task automatic t_ties();
    for (int s = 0; s < 4; s++) begin
      @(negedge clk);
      clear_all();
      now_stamp  = 16'd10;
      scan_start = 2'(s);
      for (int i = 0; i < 4; i++) put(i, 0, 16'd5);
      put(0, 2, 16'd3); put(3, 2, 16'd3); put(2, 2, 16'd8);
      step();
      check_col(0, 1, s, "R4 four-way tie follows start");
      // tie between inputs 0 and 3: scan from 1,2,3 reaches 3 first
      check_col(2, 1, (s == 0) ? 0 : 3, "R4 partial tie wrap order");
    end
  endtask

  task automatic t_empty();
    @(negedge clk);
    clear_all();
    now_stamp = 16'd77;
    step();
    for (int j = 0; j < 4; j++) check_col(j, 0, 0, "R5 all empty");
  endtask

  task automatic t_backpressure();
    @(negedge clk);
    clear_all();
    now_stamp = 16'd200;
    put(1, 1, 16'd150); put(3, 1, 16'd100);
    put(2, 0, 16'd190);
    out_ready = 4'b1101;
    step();
    check_col(1, 0, 0, "R6 stalled output silent");
    check_col(0, 1, 2, "R6 other output unaffected");
    @(negedge clk);
    out_ready = 4'hF;
    step();
    check_col(1, 1, 3, "R6 candidate kept after stall");
  endtask

  task automatic t_multi_and_timing();
    @(negedge clk);
    clear_all();
    step();
    @(negedge clk);
    now_stamp = 16'd500;
    for (int j = 0; j < 4; j++) begin
      put(2, j, 16'd1);
      put(0, j, 16'd400);
    end
    #1;
    check_col(0, 0, 0, "R7 no change before edge");
    step();
    for (int j = 0; j < 4; j++) check_col(j, 1, 2, "R9 one input wins all");
    n_tests++;
    if (deq != 16'h0F00) begin
      n_fail++;
      $display("FAIL R8: deq=%h expected 0f00", deq);
    end
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_oldest();
    t_wrap();
    t_ties();
    t_empty();
    t_backpressure();
    t_multi_and_timing();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule